// File: doc/BRIEF.md
# Synchronous Burst-Read ROM Command Engine

This block is the device-side controller of a single-bank synchronous read-only memory. On each rising clock edge it decodes a command from an active-low chip select and three active-low strobes (row, column, mode). It latches a row address and then column addresses from the same multiplexed address bus. It keeps a mode register that holds the latency, the burst ordering and the burst length. The memory cells are outside the block. The engine presents a double-word address to a combinational lookup and registers the returned data onto the output lanes. The lanes come with two enables: one for the low half and one for the high half. A pad ring outside the block turns the enables into tri-state control.

The width is chosen per Read command. Reads can follow each other without gaps, and a new command that arrives early discards the read still being sensed. Burst termination, a two-cycle output mask and a registered clock enable are also supported. The clock enable either suspends a running burst or holds an idle device in power down.

Top module: `sbrom_engine`

## Requirements
- R1: After reset both output enables are low and the mode register holds latency 5, sequential order and 4 beats, so a Read issued right after a Row Active without any mode write bursts with those settings.
- R2: With `csN` low, the strobe pattern {rasN,casN,mrN} decodes as follows: 011 is Row Active, 101 is Read, 110 is Burst Stop, 010 is Precharge (same effect as Burst Stop), 000 is Mode Set. Codes 100 and 001, and any pattern with `csN` high, produce no output activity.
- R3: A Mode Set takes latency from addr[5:3] (011=4, 100=5, 101=6), order from addr[2] (0 sequential, 1 interleaved) and length from addr[1:0] (10=4, 11=8). A Mode Set with any other latency or length code, or with addr[8:7] not zero, leaves the register unchanged.
- R4: The three clock edges that follow an accepted Mode Set ignore every command.
- R5: With latency L, the first beat of a Read sampled at edge n is driven after edge n+L-1, so it is valid at edge n+L. The burst then drives one beat per edge for its length, and both enables drop after the last beat.
- R6: `wideSel` sampled high with a Read gives 32-bit beats with column addr[7:0]. Sampled low, it gives 16-bit beats on dqOut[15:0] with column addr[8:0], where an even column selects array bits [15:0] and an odd one selects bits [31:16]; `dqOeHi` stays low. The array address is {row, double-word column}.
- R7: Beat k of a burst of length B uses column (c with its low log2(B) bits replaced by (c+k) mod B) in sequential order, or by (c XOR k) in interleaved order.
- R8: A Read sampled L-1 or more edges after the previous Read lets the earlier burst run until the new burst's first beat, with no idle cycle.
- R9: A Read or Row Active sampled fewer than L-1 edges after the previous Read cancels that Read, and none of its data is driven.
- R10: Burst Stop or Precharge sampled at edge n ends output at edge n+L-1. The last driven beat is the one launched at edge n+L-2.
- R11: `dqm` high at an enabled edge forces both enables low for the beat launched at the next enabled edge. The burst still advances.
- R12: `cke` low sampled at an edge freezes all internal state and the outputs at the following edge. Operation resumes one edge after `cke` is sampled high again.
- R13: A power-down period (cke low while idle) keeps the latched row and the mode register.
- R14: The latched row is used by every Read until the next accepted Row Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| cke | input | 1 | Clock enable, gates the following edge |
| csN | input | 1 | Active-low chip select |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| mrN | input | 1 | Active-low mode strobe |
| wideSel | input | 1 | Read width: 1 = 32-bit, 0 = 16-bit |
| dqm | input | 1 | Output mask, effective two edges later |
| addr | input | 13 | Multiplexed row / column / mode address |
| arrayAddr | output | 21 | Double-word address to the array lookup |
| arrayData | input | 32 | Double word returned by the array lookup |
| dqOut | output | 32 | Registered output data |
| dqOeLo | output | 1 | Drive enable for dqOut[15:0] |
| dqOeHi | output | 1 | Drive enable for dqOut[31:16] |

## Verification
The bench goes after the latency boundary between gapless and cancelled reads. A Read placed exactly L-1 edges after the previous one must keep both bursts. A Read placed one edge sooner must erase the first burst completely. A design that is off by one here either loses beats or drives stale data. Wrap and interleave patterns are checked for columns that start mid-block, where a design that carries past the block edge reads the wrong column. Stop timing, the mask delay and suspend in the middle of a burst are each checked against an exact cycle: a misplaced register shows up as one extra or one missing beat. Illegal mode codes, commands issued in the blackout window and the unused strobe codes must all leave no trace at the outputs.

// File: rtl/sbrom_pkg.sv
`timescale 1ns/1ps
package sbrom_pkg;
  localparam int ROW_W    = 13;
  localparam int COL_W    = 9;
  localparam int DWCOL_W  = COL_W - 1;
  localparam int ARR_W    = ROW_W + DWCOL_W;
  localparam int DQ_W     = 32;
  localparam int HALF_W   = DQ_W / 2;
  localparam int BEAT_W   = 3;
  localparam int WAIT_W   = 3;
  localparam int BLK_W    = 2;
  localparam int BLACKOUT = 3;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ROW, CMD_READ, CMD_STOP, CMD_MODE
  } cmd_e;

  // one launched beat: strobe bundle from control to datapath
  typedef struct packed {
    logic              valid;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              wide;
    logic [BEAT_W-1:0] beat;
    logic              bl8;
    logic              ilv;
  } beat_t;
endpackage

// File: rtl/sbrom_ctrl.sv
`timescale 1ns/1ps
module sbrom_ctrl
  import sbrom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             mrN,
  input  logic             wideSel,
  input  logic [ROW_W-1:0] addr,
  output logic             en,
  output beat_t            ld
);
  logic              ckeQ;
  beat_t             pend, act;
  logic [WAIT_W-1:0] pendWait, stopWait;
  logic [BLK_W-1:0]  blackCnt;
  logic [2:0]        clVal;
  logic              modeIlv, modeBl8;
  logic [ROW_W-1:0]  rowReg;
  cmd_e              cmd;
  logic              accept, startNow, stopNow, lastBeat, modeOk;
  logic [WAIT_W-1:0] clMinus1;

  assign en = ckeQ;

  always_comb begin
    cmd = CMD_NONE;
    if (!csN) begin
      unique case ({rasN, casN, mrN})
        3'b011:  cmd = CMD_ROW;
        3'b101:  cmd = CMD_READ;
        3'b110:  cmd = CMD_STOP;
        3'b010:  cmd = CMD_STOP;
        3'b000:  cmd = CMD_MODE;
        default: cmd = CMD_NONE;
      endcase
    end
  end

  assign accept   = ckeQ && (blackCnt == '0);
  assign modeOk   = (addr[5:3] inside {3'b011, 3'b100, 3'b101}) && addr[1]
                    && (addr[8:7] == 2'b00);
  assign clMinus1 = WAIT_W'(clVal - 3'd1);
  assign startNow = pend.valid && (pendWait == WAIT_W'(1));
  assign stopNow  = (stopWait == WAIT_W'(1));
  assign lastBeat = act.beat == (act.bl8 ? BEAT_W'(7) : BEAT_W'(3));

  always_comb begin
    ld = '0;
    if (startNow) begin
      ld       = pend;
      ld.valid = 1'b1;
      ld.beat  = '0;
    end else if (act.valid && !stopNow && !lastBeat) begin
      ld      = act;
      ld.beat = act.beat + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeQ     <= 1'b1;
      pend     <= '0;
      act      <= '0;
      pendWait <= '0;
      stopWait <= '0;
      blackCnt <= '0;
      clVal    <= 3'd5;
      modeIlv  <= 1'b0;
      modeBl8  <= 1'b0;
      rowReg   <= '0;
    end else begin
      ckeQ <= cke;
      if (ckeQ) begin
        act <= ld;
        if (startNow)        pend.valid <= 1'b0;
        else if (pend.valid) pendWait   <= pendWait - 1'b1;
        if (stopWait != '0)  stopWait   <= stopWait - 1'b1;
        if (blackCnt != '0)  blackCnt   <= blackCnt - 1'b1;
        if (accept) begin
          unique case (cmd)
            CMD_ROW: begin
              rowReg <= addr;
              if (pend.valid && !startNow) pend.valid <= 1'b0;
            end
            CMD_READ: begin
              pend.valid <= 1'b1;
              pend.row   <= rowReg;
              pend.col   <= wideSel ? {1'b0, addr[DWCOL_W-1:0]} : addr[COL_W-1:0];
              pend.wide  <= wideSel;
              pend.beat  <= '0;
              pend.bl8   <= modeBl8;
              pend.ilv   <= modeIlv;
              pendWait   <= clMinus1;
            end
            CMD_STOP: if (stopWait == '0) stopWait <= clMinus1;
            CMD_MODE: begin
              blackCnt <= BLK_W'(BLACKOUT);
              if (modeOk) begin
                clVal   <= addr[5:3] + 3'd1;
                modeIlv <= addr[2];
                modeBl8 <= addr[0];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R3: only legal latencies ever reach the register
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    clVal inside {3'd4, 3'd5, 3'd6});
  // R5: a burst never runs past its programmed length
  p_beat_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    act.valid |-> (act.beat <= (act.bl8 ? BEAT_W'(7) : BEAT_W'(3))));
  // R4: the row cannot move while the blackout window is open
  p_blackout_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ckeQ && blackCnt != '0) |=> $stable(rowReg));
  // R12: a disabled edge leaves burst and row state untouched
  p_freeze_state_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ckeQ |=> ($stable(act) && $stable(rowReg) && $stable(pend)));
endmodule

// File: rtl/sbrom_datapath.sv
`timescale 1ns/1ps
module sbrom_datapath
  import sbrom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  beat_t            ld,
  input  logic             dqm,
  output logic [ARR_W-1:0] arrayAddr,
  input  logic [DQ_W-1:0]  arrayData,
  output logic [DQ_W-1:0]  dqOut,
  output logic             dqOeLo,
  output logic             dqOeHi
);
  logic [COL_W-1:0] blkMask, lowBits, stepBits, beatCol;
  logic             maskQ;
  logic [DQ_W-1:0]  beatData;

  always_comb begin
    blkMask  = ld.bl8 ? COL_W'(7) : COL_W'(3);
    lowBits  = ld.col & blkMask;
    stepBits = ld.ilv ? (lowBits ^ COL_W'(ld.beat))
                      : ((lowBits + COL_W'(ld.beat)) & blkMask);
    beatCol  = (ld.col & ~blkMask) | stepBits;
  end

  assign arrayAddr = ld.wide ? {ld.row, beatCol[DWCOL_W-1:0]}
                             : {ld.row, beatCol[COL_W-1:1]};

  assign beatData = ld.wide ? arrayData
                  : {{HALF_W{1'b0}}, beatCol[0] ? arrayData[DQ_W-1:HALF_W]
                                                : arrayData[HALF_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= 1'b0;
      dqOut  <= '0;
      dqOeLo <= 1'b0;
      dqOeHi <= 1'b0;
    end else if (en) begin
      maskQ <= dqm;
      if (ld.valid) dqOut <= beatData;
      dqOeLo <= ld.valid && !maskQ;
      dqOeHi <= ld.valid && !maskQ && ld.wide;
    end
  end

  // R6: the upper lane is never driven alone
  p_hi_needs_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    dqOeHi |-> dqOeLo);
  // R6: a 16-bit beat keeps the upper lane off
  p_narrow_upper_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (en && ld.valid && !ld.wide) |=> !dqOeHi);
  // R12: outputs hold through a suspended edge
  p_freeze_out_r12: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(dqOut) && $stable(dqOeLo) && $stable(dqOeHi)));
endmodule

// File: rtl/sbrom_engine.sv
`timescale 1ns/1ps
module sbrom_engine
  import sbrom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             mrN,
  input  logic             wideSel,
  input  logic             dqm,
  input  logic [ROW_W-1:0] addr,
  output logic [ARR_W-1:0] arrayAddr,
  input  logic [DQ_W-1:0]  arrayData,
  output logic [DQ_W-1:0]  dqOut,
  output logic             dqOeLo,
  output logic             dqOeHi
);
  logic  en;
  beat_t ld;

  sbrom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .mrN(mrN), .wideSel(wideSel), .addr(addr),
    .en(en), .ld(ld)
  );

  sbrom_datapath u_dp (
    .clk(clk), .rstN(rstN), .en(en), .ld(ld), .dqm(dqm),
    .arrayAddr(arrayAddr), .arrayData(arrayData),
    .dqOut(dqOut), .dqOeLo(dqOeLo), .dqOeHi(dqOeHi)
  );
endmodule

// File: tb/sbrom_engine_tb.sv
`timescale 1ns/1ps
module sbrom_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, mrN = 1'b1;
  logic        wideSel = 1'b0, dqm = 1'b0;
  logic [12:0] addr = '0;
  logic [20:0] arrayAddr;
  logic [31:0] arrayData, dqOut;
  logic        dqOeLo, dqOeHi;

  int    nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit    started = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] memFn(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A0F_C3E1;
  endfunction

  assign arrayData = memFn(int'(arrayAddr));

  sbrom_engine u_dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .mrN(mrN), .wideSel(wideSel), .dqm(dqm), .addr(addr),
    .arrayAddr(arrayAddr), .arrayData(arrayData),
    .dqOut(dqOut), .dqOeLo(dqOeLo), .dqOeHi(dqOeHi)
  );

  // ---------------- behavioural reference model ----------------
  bit          eV[int];
  bit          eW[int];
  logic [31:0] eD[int];
  int          eO[int];
  int  tNow, blk, mCL, mBL, rowM, lastT, lastCL, lastId, idc;
  bit  mIlv, lastV, ckeM, maskM, enM, mk;
  bit  expLo, expHi;
  logic [31:0] expD;

  function automatic void dropFrom(input int t);
    int ks[$];
    foreach (eV[k]) if (k >= t) ks.push_back(k);
    foreach (ks[i]) begin
      eV.delete(ks[i]); eW.delete(ks[i]); eD.delete(ks[i]); eO.delete(ks[i]);
    end
  endfunction

  function automatic void dropOwner(input int id);
    int ks[$];
    foreach (eO[k]) if (eO[k] == id) ks.push_back(k);
    foreach (ks[i]) begin
      eV.delete(ks[i]); eW.delete(ks[i]); eD.delete(ks[i]); eO.delete(ks[i]);
    end
  endfunction

  function automatic void killCheck();
    if (lastV && (tNow - lastT) < (lastCL - 1)) dropOwner(lastId);
    lastV = 0;
  endfunction

  function automatic void schedule(input int a, input bit w);
    int col, off, base, bc, st;
    logic [31:0] dw;
    col  = w ? (a % 256) : (a % 512);
    off  = col % mBL;
    base = col - off;
    st   = tNow + mCL - 1;
    idc++;
    dropFrom(st);
    for (int k = 0; k < mBL; k++) begin
      bc = mIlv ? base + (off ^ k) : base + ((off + k) % mBL);
      if (w) dw = memFn(rowM * 256 + bc);
      else begin
        dw = memFn(rowM * 256 + bc / 2);
        dw = (bc % 2 == 1) ? {16'h0, dw[31:16]} : {16'h0, dw[15:0]};
      end
      eV[st+k] = 1; eW[st+k] = w; eD[st+k] = dw; eO[st+k] = idc;
    end
    lastV = 1; lastT = tNow; lastCL = mCL; lastId = idc;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      tNow = 0; blk = 0; mCL = 5; mBL = 4; mIlv = 0; rowM = 0;
      lastV = 0; idc = 0; ckeM = 1; maskM = 0;
      expLo = 0; expHi = 0; expD = '0;
      eV.delete(); eW.delete(); eD.delete(); eO.delete();
    end else begin
      enM = ckeM; ckeM = cke;
      if (enM) begin
        tNow++;
        mk = maskM; maskM = dqm;
        if (blk > 0) blk--;
        else if (!csN) begin
          case ({rasN, casN, mrN})
            3'b011: begin killCheck(); rowM = int'(addr); end
            3'b101: begin killCheck(); schedule(int'(addr), wideSel); end
            3'b110, 3'b010: dropFrom(tNow + mCL - 1);
            3'b000: begin
              blk = 3;
              if ((((addr >> 3) & 7) inside {3, 4, 5}) && addr[1] && addr[8:7] == 0) begin
                mCL  = int'((addr >> 3) & 7) + 1;
                mIlv = addr[2];
                mBL  = addr[0] ? 8 : 4;
              end
            end
            default: ;
          endcase
        end
        if (eV.exists(tNow)) begin
          expLo = !mk; expHi = !mk && eW[tNow]; expD = eD[tNow];
        end else begin
          expLo = 0; expHi = 0;
        end
      end
    end
  end

  // ---------------- cycle comparison ----------------
  always @(negedge clk) begin
    if (started && rstN) begin
      nChecks++;
      if (dqOeLo !== expLo || dqOeHi !== expHi ||
          (expLo && dqOut[15:0] !== expD[15:0]) ||
          (expHi && dqOut[31:16] !== expD[31:16])) begin
        nFails++;
        $display("FAIL %s t=%0d: oeLo=%b oeHi=%b dq=%h expected oeLo=%b oeHi=%b dq=%h",
                 curReq, tNow, dqOeLo, dqOeHi, dqOut, expLo, expHi, expD);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input logic r, input logic c, input logic m, input int a, input logic w);
    @(negedge clk); csN = 0; rasN = r; casN = c; mrN = m; addr = 13'(a); wideSel = w;
  endtask
  task automatic nop(input int k);
    repeat (k) begin @(negedge clk); csN = 1; rasN = 1; casN = 1; mrN = 1; end
  endtask
  task automatic rowAct(input int a);          issue(0, 1, 1, a, 0); endtask
  task automatic rd(input int a, input logic w); issue(1, 0, 1, a, w); endtask
  task automatic bstop();                      issue(1, 1, 0, 0, 0); endtask
  task automatic prech();                      issue(0, 1, 0, 0, 0); endtask
  task automatic mset(input int a);            issue(0, 0, 0, a, 0); endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    nChecks++;
    if (dqOeLo !== 1'b0 || dqOeHi !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: oeLo=%b oeHi=%b expected 0 0", dqOeLo, dqOeHi);
    end
    rstN = 1; started = 1;
    // R1: default mode, Row Active as first command
    curReq = "R1"; rowAct(5); rd(2, 1); nop(12);
    // R6: widths and half select
    curReq = "R6"; rd(6, 0); nop(4); rd(7, 0); nop(10); rd(255, 1); nop(12);
    // R3/R7: CL4 interleaved BL8, then CL6 sequential BL8
    curReq = "R3"; mset(6'b011_1_11); nop(3);
    curReq = "R7"; rd(13, 0); nop(14); rd(5, 1); nop(14);
    curReq = "R3"; mset(6'b101_0_11); nop(3); rd(10, 1); nop(16);
    mset(6'b111_0_11); nop(3); rd(3, 0); nop(16);
    mset(9'h080 | 6'b100_0_10); nop(3); rd(9, 1); nop(16);
    // R4: commands inside the blackout window
    curReq = "R4"; mset(6'b100_0_10); rd(1, 1); rowAct(99); rd(2, 1); rd(4, 1); nop(12);
    // R7: sequential wrap mid-block at BL4
    curReq = "R7"; rd(3, 1); nop(12);
    // R8: gapless at exactly CL-1
    curReq = "R8"; rd(0, 1); nop(3); rd(8, 0); nop(3); rowAct(6); nop(12);
    // R9: early Read and early Row Active cancel
    curReq = "R9"; rd(16, 1); nop(1); rd(20, 1); nop(12);
    rd(24, 1); nop(2); rowAct(7); nop(12);
    // R10: stop and precharge code with BL8
    curReq = "R10"; mset(6'b100_0_11); nop(3);
    rd(32, 1); nop(5); bstop(); nop(14);
    rd(40, 0); nop(6); prech(); nop(14);
    // R11: output mask pulses
    curReq = "R11"; rd(48, 1); nop(4);
    @(negedge clk); dqm = 1; @(negedge clk); dqm = 0; nop(1);
    @(negedge clk); dqm = 1; @(negedge clk); nop(1); dqm = 0; nop(12);
    // R12: suspend during latency and during burst
    curReq = "R12"; rd(56, 1); nop(1);
    @(negedge clk); cke = 0; repeat (2) @(negedge clk); cke = 1;
    nop(4); @(negedge clk); cke = 0; repeat (3) @(negedge clk); cke = 1; nop(16);
    // R13: power down keeps row and mode
    curReq = "R13"; rowAct(77); nop(2);
    @(negedge clk); cke = 0; repeat (6) @(negedge clk); cke = 1; nop(2);
    rd(11, 1); nop(16);
    // R14: row persists across reads
    curReq = "R14"; rowAct(300); nop(1); rd(1, 0); nop(14); rd(17, 1); nop(14);
    // R2: unused and deselected codes
    curReq = "R2"; issue(1, 0, 0, 5, 1); issue(0, 0, 1, 5, 1); nop(1);
    @(negedge clk); csN = 1; rasN = 1; casN = 0; mrN = 1; addr = 13'd5; nop(14);
    curReq = "R2"; rd(2, 1); nop(14);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule